// File: doc/BRIEF.md
# Predicated Condition-Gated Writeback Unit

This unit decides, for a group of vector elements processed side by side, what reaches the destination registers. Each lane carries three inputs: a predicate bit, a computed result, and an overflow flag from the arithmetic stage. From the result and the flag the unit forms a 4-bit condition field. It then tests one selected bit of that field against an expected value. The outcome gates the result store. The condition field has its own write enable and can still be stored when the result store is cancelled. That lets later code find out which elements failed the test.

Zeroing is optional. When it is on, lanes that are masked out and lanes that fail the test both write zero in place of the result. In condition-only mode the unit acts like a compare: the condition fields are written and no result is ever written.

Lanes do not interact. The decision is registered once, so the enables for a group appear one cycle after the group is presented. Each lane moves through a named action: SKIP (no result write), STORE (write the result) or ZERO (write zero). The action is chosen when the group is accepted (the accept transition) and is dropped back to SKIP on any cycle with no valid group (the idle transition).

Top module: `pcwb_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid_o`, `res_we_o`, `zero_sel_o` and `cr_we_o` are all zero.
- R2: Outputs for a group presented with `in_valid_i` high at a clock edge appear after that edge and last one cycle. `out_valid_o` equals `in_valid_i` delayed by one cycle. When `out_valid_o` is low, every write enable is low.
- R3: Lane i's condition field is `cr_field_o[4i+3:4i]`, with bit 3 = less-than (result negative as a two's-complement value), bit 2 = greater-than (positive and nonzero), bit 1 = equal (result zero), and bit 0 = the lane's overflow input.
- R4: For a lane whose predicate bit is 1, `cr_we_o` is 1 exactly when `rec_cr_i` or `cr_only_i` is set. This holds whether or not the lane's test passes.
- R5: The test of a lane passes when bit `sel_i` of its condition field equals `expect_i`. For a predicated-on lane outside condition-only mode, a passing test gives `res_we_o`=1, `zero_sel_o`=0 and `wb_data_o` equal to the lane's result.
- R6: With `cr_only_i` set, lanes whose predicate bit is 1 have `res_we_o`=0 and `zero_sel_o`=0 whatever their test outcome.
- R7: With `zero_en_i` set, a masked-out lane, or a predicated-on lane outside condition-only mode that fails its test, gets `res_we_o`=1, `zero_sel_o`=1 and `wb_data_o` lane bits zero.
- R8: With `zero_en_i` clear, masked-out lanes and failing lanes have `res_we_o`=0. A masked-out lane never has `cr_we_o`=1. In every lane that is not storing its result, `wb_data_o` is zero.
- R9: Each lane's outputs depend only on that lane's inputs and on the shared controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | A lane group is presented this cycle |
| pred_i | input | LANES | Predicate bit per lane |
| result_i | input | LANES*W | Computed result per lane, lane i at bits [W*i+W-1:W*i] |
| ovf_i | input | LANES | Overflow/saturation flag per lane |
| sel_i | input | 2 | Index of the condition bit to test (0 ovf, 1 eq, 2 gt, 3 lt) |
| expect_i | input | 1 | Value the selected bit must equal for the store to proceed |
| rec_cr_i | input | 1 | Record the condition field |
| cr_only_i | input | 1 | Condition-only mode: write fields, never results |
| zero_en_i | input | 1 | Destination zeroing |
| out_valid_o | output | 1 | Registered group valid |
| res_we_o | output | LANES | Result-register write enable per lane |
| zero_sel_o | output | LANES | Write zero instead of the result |
| cr_we_o | output | LANES | Condition-field write enable per lane |
| cr_field_o | output | LANES*4 | Condition field per lane |
| wb_data_o | output | LANES*W | Data to write per lane |

## Verification
The hardest case to reach is a single group in which one lane passes, one fails, and one is masked out, with zeroing, record and condition-only all in a chosen combination. Only that case shows that the store gating, the zeroing and the field enable are separate per lane. Uniformly random results almost never produce the zero result that sets the equal bit. The random stimulus therefore picks each lane's result from a skewed mix: zero, small negative, small positive or full-range. It also draws each predicate bit and mode control on its own. Directed groups then cover all-masked zeroing, condition-only with zeroing, and every value of the bit select with both expected values.

// File: rtl/pcwb_pkg.sv
package pcwb_pkg;

    localparam int CF_W   = 4;
    localparam int CF_OVF = 0;
    localparam int CF_EQ  = 1;
    localparam int CF_GT  = 2;
    localparam int CF_LT  = 3;

    typedef enum logic [1:0] {
        LANE_SKIP  = 2'd0,
        LANE_STORE = 2'd1,
        LANE_ZERO  = 2'd2
    } lane_act_e;

endpackage

// File: rtl/pcwb_cond_gen.sv
module pcwb_cond_gen
    import pcwb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]    value_i,
    input  logic            ovf_i,
    output logic [CF_W-1:0] field_o
);
    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg  = value_i[W-1];
        is_zero = (value_i == '0);
        field_o          = '0;
        field_o[CF_LT]   = is_neg;
        field_o[CF_GT]   = !is_neg && !is_zero;
        field_o[CF_EQ]   = is_zero;
        field_o[CF_OVF]  = ovf_i;
    end
endmodule

// File: rtl/pcwb_lane_decide.sv
module pcwb_lane_decide
    import pcwb_pkg::*;
(
    input  logic            active_i,
    input  logic [CF_W-1:0] field_i,
    input  logic [1:0]      sel_i,
    input  logic            expect_i,
    input  logic            rec_cr_i,
    input  logic            cr_only_i,
    input  logic            zero_en_i,
    output lane_act_e       act_o,
    output logic            cr_we_o
);
    logic hit;

    always_comb begin
        hit     = (field_i[sel_i] == expect_i);
        cr_we_o = active_i && (rec_cr_i || cr_only_i);
        unique case ({active_i, cr_only_i, hit})
            3'b000, 3'b001, 3'b010, 3'b011:
                act_o = zero_en_i ? LANE_ZERO : LANE_SKIP;
            3'b110, 3'b111:
                act_o = LANE_SKIP;
            3'b101:
                act_o = LANE_STORE;
            3'b100:
                act_o = zero_en_i ? LANE_ZERO : LANE_SKIP;
            default:
                act_o = LANE_SKIP;
        endcase
    end
endmodule

// File: rtl/pcwb_top.sv
module pcwb_top
    import pcwb_pkg::*;
#(
    parameter int LANES = 4,
    parameter int W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid_i,
    input  logic [LANES-1:0]     pred_i,
    input  logic [LANES*W-1:0]   result_i,
    input  logic [LANES-1:0]     ovf_i,
    input  logic [1:0]           sel_i,
    input  logic                 expect_i,
    input  logic                 rec_cr_i,
    input  logic                 cr_only_i,
    input  logic                 zero_en_i,
    output logic                 out_valid_o,
    output logic [LANES-1:0]     res_we_o,
    output logic [LANES-1:0]     zero_sel_o,
    output logic [LANES-1:0]     cr_we_o,
    output logic [LANES*CF_W-1:0] cr_field_o,
    output logic [LANES*W-1:0]   wb_data_o
);
    localparam int FIELD_BITS = LANES * CF_W;

    lane_act_e [LANES-1:0] act_d;
    lane_act_e [LANES-1:0] act_q;
    logic [LANES-1:0]      crwe_d;
    logic [LANES-1:0]      crwe_q;
    logic [FIELD_BITS-1:0] field_d;
    logic [FIELD_BITS-1:0] field_q;
    logic [LANES*W-1:0]    res_q;
    logic                  vld_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pcwb_cond_gen #(.W(W)) u_cond (
            .value_i (result_i[g*W +: W]),
            .ovf_i   (ovf_i[g]),
            .field_o (field_d[g*CF_W +: CF_W])
        );

        pcwb_lane_decide u_decide (
            .active_i  (pred_i[g]),
            .field_i   (field_d[g*CF_W +: CF_W]),
            .sel_i     (sel_i),
            .expect_i  (expect_i),
            .rec_cr_i  (rec_cr_i),
            .cr_only_i (cr_only_i),
            .zero_en_i (zero_en_i),
            .act_o     (act_d[g]),
            .cr_we_o   (crwe_d[g])
        );
    end

    // State register: accept transition loads new actions, idle transition returns to SKIP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            crwe_q  <= '0;
            field_q <= '0;
            res_q   <= '0;
            for (int i = 0; i < LANES; i++) act_q[i] <= LANE_SKIP;
        end else if (in_valid_i) begin
            vld_q   <= 1'b1;
            crwe_q  <= crwe_d;
            field_q <= field_d;
            res_q   <= result_i;
            act_q   <= act_d;
        end else begin
            vld_q   <= 1'b0;
            crwe_q  <= '0;
            for (int i = 0; i < LANES; i++) act_q[i] <= LANE_SKIP;
        end
    end

    // Output process: map each lane action onto enables and data
    always_comb begin
        out_valid_o = vld_q;
        cr_we_o     = crwe_q;
        cr_field_o  = field_q;
        res_we_o    = '0;
        zero_sel_o  = '0;
        wb_data_o   = '0;
        for (int i = 0; i < LANES; i++) begin
            unique case (act_q[i])
                LANE_STORE: begin
                    res_we_o[i]           = 1'b1;
                    wb_data_o[i*W +: W]   = res_q[i*W +: W];
                end
                LANE_ZERO: begin
                    res_we_o[i]   = 1'b1;
                    zero_sel_o[i] = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pcwb_checker.sv
module pcwb_checker #(
    parameter int LANES = 4,
    parameter int W     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid_i,
    input logic [LANES-1:0]     pred_i,
    input logic                 rec_cr_i,
    input logic                 cr_only_i,
    input logic                 out_valid_o,
    input logic [LANES-1:0]     res_we_o,
    input logic [LANES-1:0]     zero_sel_o,
    input logic [LANES-1:0]     cr_we_o,
    input logic [LANES*W-1:0]   wb_data_o
);
    // R2: valid follows input by one cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);
    p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (res_we_o == '0 && cr_we_o == '0));

    // R4: active lanes record the field whenever requested
    p_crwe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && (rec_cr_i || cr_only_i)) |=> (cr_we_o == $past(pred_i)));

    // R6: condition-only mode never stores a result in an active lane
    p_cronly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && cr_only_i) |=> ((res_we_o & $past(pred_i)) == '0));

    // R7: zero selection always comes with a write
    p_zero_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_sel_o & ~res_we_o) == '0);

    // R8: masked lanes never write a condition field
    p_mask_nocr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> ((cr_we_o & ~$past(pred_i)) == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R7: zeroed lane carries zero data
        p_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
            zero_sel_o[g] |-> (wb_data_o[g*W +: W] == '0));
    end
endmodule

bind pcwb_top pcwb_checker #(.LANES(LANES), .W(W)) u_pcwb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .pred_i      (pred_i),
    .rec_cr_i    (rec_cr_i),
    .cr_only_i   (cr_only_i),
    .out_valid_o (out_valid_o),
    .res_we_o    (res_we_o),
    .zero_sel_o  (zero_sel_o),
    .cr_we_o     (cr_we_o),
    .wb_data_o   (wb_data_o)
);

// File: tb/pcwb_top_bench.sv
module pcwb_top_bench;
    localparam int LANES = 4;
    localparam int W     = 16;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid_i;
    logic [LANES-1:0]     pred_i;
    logic [LANES*W-1:0]   result_i;
    logic [LANES-1:0]     ovf_i;
    logic [1:0]           sel_i;
    logic                 expect_i;
    logic                 rec_cr_i;
    logic                 cr_only_i;
    logic                 zero_en_i;
    logic                 out_valid_o;
    logic [LANES-1:0]     res_we_o;
    logic [LANES-1:0]     zero_sel_o;
    logic [LANES-1:0]     cr_we_o;
    logic [LANES*4-1:0]   cr_field_o;
    logic [LANES*W-1:0]   wb_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pcwb_top #(.LANES(LANES), .W(W)) u_pcwb_top (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .pred_i(pred_i),
        .result_i(result_i), .ovf_i(ovf_i), .sel_i(sel_i), .expect_i(expect_i),
        .rec_cr_i(rec_cr_i), .cr_only_i(cr_only_i), .zero_en_i(zero_en_i),
        .out_valid_o(out_valid_o), .res_we_o(res_we_o), .zero_sel_o(zero_sel_o),
        .cr_we_o(cr_we_o), .cr_field_o(cr_field_o), .wb_data_o(wb_data_o)
    );

    function automatic logic [3:0] exp_field(logic [W-1:0] v, logic ov);
        logic lt, eq;
        lt = v[W-1];
        eq = (v == '0);
        return {lt, !lt && !eq, eq, ov};
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Apply one group at negedge, check the registered outputs at the next negedge.
    task automatic apply_group();
        logic [3:0]   f;
        logic         hit, exp_we, exp_zs, exp_cw;
        logic [W-1:0] exp_d;
        string        req;
        in_valid_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R2", "out_valid", 64'(out_valid_o), 64'd1);
        for (int i = 0; i < LANES; i++) begin
            f   = exp_field(result_i[i*W +: W], ovf_i[i]);
            hit = (f[sel_i] == expect_i);
            exp_cw = pred_i[i] && (rec_cr_i || cr_only_i);
            if (!pred_i[i]) begin
                exp_we = zero_en_i; exp_zs = zero_en_i; exp_d = '0;
                req = zero_en_i ? "R7" : "R8";
            end else if (cr_only_i) begin
                exp_we = 1'b0; exp_zs = 1'b0; exp_d = '0; req = "R6";
            end else if (hit) begin
                exp_we = 1'b1; exp_zs = 1'b0; exp_d = result_i[i*W +: W]; req = "R5";
            end else begin
                exp_we = zero_en_i; exp_zs = zero_en_i; exp_d = '0;
                req = zero_en_i ? "R7" : "R8";
            end
            check("R3", $sformatf("lane%0d field", i), 64'(cr_field_o[i*4 +: 4]), 64'(f));
            check(pred_i[i] ? "R4" : "R8", $sformatf("lane%0d cr_we", i), 64'(cr_we_o[i]), 64'(exp_cw));
            check(req, $sformatf("lane%0d res_we", i), 64'(res_we_o[i]), 64'(exp_we));
            check(req, $sformatf("lane%0d zero_sel", i), 64'(zero_sel_o[i]), 64'(exp_zs));
            check(req, $sformatf("lane%0d data", i), 64'(wb_data_o[i*W +: W]), 64'(exp_d));
        end
    endtask

    function automatic logic [W-1:0] pick_value();
        unique case ($urandom % 4)
            0: return '0;
            1: return W'(-int'($urandom % 8) - 1);
            2: return W'(($urandom % 8) + 1);
            default: return W'($urandom);
        endcase
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        rst_n = 1'b0; in_valid_i = 1'b0; pred_i = '0; result_i = '0; ovf_i = '0;
        sel_i = '0; expect_i = 1'b0; rec_cr_i = 1'b0; cr_only_i = 1'b0; zero_en_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_valid", 64'(out_valid_o), 64'd0);
        check("R1", "res_we", 64'(res_we_o), 64'd0);
        check("R1", "cr_we", 64'(cr_we_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "post-reset enables", 64'({res_we_o, zero_sel_o, cr_we_o}), 64'd0);
        // R2: idle cycle with controls set produces no writes
        pred_i = '1; zero_en_i = 1'b1; rec_cr_i = 1'b1;
        @(negedge clk);
        check("R2", "idle res_we", 64'(res_we_o), 64'd0);
        check("R2", "idle cr_we", 64'(cr_we_o), 64'd0);

        // Directed: all masked with zeroing (R7)
        pred_i = '0; result_i = {16'h1234, 16'hFFFF, 16'h0000, 16'h0007};
        apply_group();
        // Directed: condition-only with zeroing, mixed lanes (R6, R4)
        pred_i = 4'b1011; cr_only_i = 1'b1; sel_i = 2'd1; expect_i = 1'b1;
        apply_group();
        cr_only_i = 1'b0;
        // Directed: every select with both expected values, mixed lanes (R5, R9)
        ovf_i = 4'b0101;
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
                sel_i = 2'(s); expect_i = 1'(e); pred_i = 4'b1101;
                zero_en_i = 1'(s[0]); rec_cr_i = 1'(e);
                apply_group();
            end
        end
        // Random groups
        for (int n = 0; n < 300; n++) begin
            pred_i = 4'($urandom);
            for (int i = 0; i < LANES; i++) result_i[i*W +: W] = pick_value();
            ovf_i = 4'($urandom);
            sel_i = 2'($urandom); expect_i = 1'($urandom);
            rec_cr_i = 1'($urandom); cr_only_i = (($urandom % 4) == 0);
            zero_en_i = 1'($urandom);
            apply_group();
            if (($urandom % 5) == 0) begin
                @(negedge clk);
                check("R2", "gap res_we", 64'(res_we_o), 64'd0);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule